// File: doc/BRIEF.md
# Configurable Shared Interrupt Source Bank

This block collects a parameterised number of asynchronous interrupt lines and turns each into a pending bit. Software sets, per line, whether it is active-high or active-low, whether it is sampled as a level or as an edge, and whether any transition counts regardless of polarity. A pending bit reaches the delivered vector only when its enable is also set. A word-wide register port handles configuration and readback. The delivered vector, pending AND enable, goes straight to whatever routes interrupts to cores.

Enables are changed through a separate set-port and clear-port, so software never needs a read-modify-write. A software injection register carries a line number and a set/clear flag in one write. It can raise any line and can clear an edge-captured pending bit, which is how a handler acknowledges an edge interrupt. Each input passes through a synchroniser before any decision is made. The line count must be a multiple of 8. Registers hold 32 lines per word, and bits above the line count read as zero.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every line is active-high (polarity bit 1), level-sampled (trigger bit 0), single-edge (any-edge bit 0), disabled (enable 0), and nothing is pending.
- R2: The address is {region[2:0], word}. A write to region 3 sets every enable whose data bit is 1. A write to region 4 clears every enable whose data bit is 1. Zero data bits leave enables as they are. Both regions read back the enable word.
- R3: The delivered vector has a bit at 1 exactly when that line is both pending and enabled.
- R4: With trigger bit 0, the pending bit follows the input, inverted when polarity is 0. Pending reflects a change at the input after two clock edges.
- R5: With trigger bit 1 and any-edge bit 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets a sticky pending bit. The bit is set on the third clock edge after the input change and stays set until software clears it.
- R6: With trigger bit 1 and any-edge bit 1, both rising and falling edges set the pending bit, and the polarity bit has no effect.
- R7: A write to region 6 carries the line number in bits 15:0 and the action in bit 31 (1 = set, 0 = clear). A set makes that line pending after the write edge. A clear removes its captured pending bit.
- R8: A write to region 6 whose line number is not below the line count changes no pending bit.
- R9: If an edge is captured on the same clock edge as a software clear of that line, the line stays pending.
- R10: In the last word, bits at or above the line count read as zero and ignore writes.
- R11: Regions 0, 1 and 2 (polarity, trigger, any-edge) read back what was last written. Region 5 reads the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Asynchronous interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3+WORD_W | Region in the top three bits, word index below |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_pend_masked | output | NUM_SRC | Pending AND enable per line |

## Verification
An edge can be captured on the same clock edge that software writes a clear for that line. The bench sets a line pending, then raises its input. It times the software clear to commit on the third clock edge after that change, which is exactly when the edge detector fires. The design passes only if the line reads back as still pending, and a second clear with no edge present then empties it.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
   localparam int unsigned WORD_BITS     = 32;
   localparam int unsigned REGION_W      = 3;
   localparam int unsigned WEDGE_NUM_W   = 16;
   localparam int unsigned WEDGE_SET_BIT = 31;

   typedef enum logic [REGION_W-1:0] {
      RG_POL   = 3'd0,
      RG_TRIG  = 3'd1,
      RG_DUAL  = 3'd2,
      RG_MSET  = 3'd3,
      RG_MCLR  = 3'd4,
      RG_PEND  = 3'd5,
      RG_WEDGE = 3'd6,
      RG_NONE  = 3'd7
   } region_e;

   function automatic int unsigned words_for(input int unsigned n);
      return (n + WORD_BITS - 1) / WORD_BITS;
   endfunction

   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_src_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC = 40,
   localparam int unsigned NW     = words_for(NUM_SRC),
   localparam int unsigned WORD_W = idx_w(NW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  region_e            wr_region,
   input  logic [WORD_W-1:0]  wr_word,
   input  logic [31:0]        wr_data,
   output logic [NUM_SRC-1:0] pol_q,
   output logic [NUM_SRC-1:0] trig_q,
   output logic [NUM_SRC-1:0] dual_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] wedge_set,
   output logic [NUM_SRC-1:0] wedge_clr
);
   logic [NUM_SRC-1:0] pol_d, trig_d, dual_d, mask_d;
   logic [WEDGE_NUM_W-1:0] wedge_num;
   logic wedge_ok;
   logic unused_wdata;

   assign wedge_num    = wr_data[WEDGE_NUM_W-1:0];
   assign wedge_ok     = wr_en && (wr_region == RG_WEDGE) && (32'(wedge_num) < NUM_SRC);
   assign unused_wdata = ^wr_data[WEDGE_SET_BIT-1:WEDGE_NUM_W];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int unsigned WI = i / WORD_BITS;
      localparam int unsigned BI = i % WORD_BITS;
      logic word_hit;
      assign word_hit = wr_en && (wr_word == WORD_W'(WI));

      assign pol_d[i]  = (word_hit && wr_region == RG_POL)  ? wr_data[BI] : pol_q[i];
      assign trig_d[i] = (word_hit && wr_region == RG_TRIG) ? wr_data[BI] : trig_q[i];
      assign dual_d[i] = (word_hit && wr_region == RG_DUAL) ? wr_data[BI] : dual_q[i];
      assign mask_d[i] = (word_hit && wr_region == RG_MSET && wr_data[BI]) ? 1'b1 :
                         (word_hit && wr_region == RG_MCLR && wr_data[BI]) ? 1'b0 :
                         mask_q[i];

      assign wedge_set[i] = wedge_ok &&  wr_data[WEDGE_SET_BIT] && (wedge_num == WEDGE_NUM_W'(i));
      assign wedge_clr[i] = wedge_ok && !wr_data[WEDGE_SET_BIT] && (wedge_num == WEDGE_NUM_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '1;
         trig_q <= '0;
         dual_q <= '0;
         mask_q <= '0;
      end else begin
         pol_q  <= pol_d;
         trig_q <= trig_d;
         dual_q <= dual_d;
         mask_q <= mask_d;
      end
   end
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
   parameter int unsigned NUM_SRC = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lvl,
   input  logic [NUM_SRC-1:0] pol,
   input  logic [NUM_SRC-1:0] trig,
   input  logic [NUM_SRC-1:0] dual,
   input  logic [NUM_SRC-1:0] wset,
   input  logic [NUM_SRC-1:0] wclr,
   output logic [NUM_SRC-1:0] latch_q,
   output logic [NUM_SRC-1:0] pend
);
   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] latch_d;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic active, rise, fall, edge_hit;
      assign active   = pol[i] ? lvl[i] : ~lvl[i];
      assign rise     =  lvl[i] & ~prev_q[i];
      assign fall     = ~lvl[i] &  prev_q[i];
      assign edge_hit = trig[i] & (dual[i] ? (rise | fall) : (pol[i] ? rise : fall));
      assign latch_d[i] = (edge_hit | wset[i]) ? 1'b1 :
                          wclr[i]              ? 1'b0 :
                          latch_q[i];
      assign pend[i] = latch_q[i] | (~trig[i] & active);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= lvl;
         latch_q <= latch_d;
      end
   end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 40,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NW         = words_for(NUM_SRC),
   localparam int unsigned WORD_W     = idx_w(NW),
   localparam int unsigned ADDR_W     = REGION_W + WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NUM_SRC-1:0] irq_pend_masked
);
   localparam int unsigned PAD_W = NW * WORD_BITS;

   if ((NUM_SRC % 8) != 0 || NUM_SRC < 8) begin : g_bad_count
      $error("irq_src_bank: NUM_SRC must be a nonzero multiple of 8");
   end
   if (NUM_SRC >= (1 << WEDGE_NUM_W)) begin : g_bad_wedge
      $error("irq_src_bank: NUM_SRC exceeds the injection number field");
   end

   region_e            region;
   logic [WORD_W-1:0]  word_idx;
   logic [NUM_SRC-1:0] lvl_sync;
   logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, mask_q;
   logic [NUM_SRC-1:0] wedge_set, wedge_clr;
   logic [NUM_SRC-1:0] latch_q, pend;

   assign region   = region_e'(reg_addr[ADDR_W-1 -: REGION_W]);
   assign word_idx = reg_addr[WORD_W-1:0];

   irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_in),
      .q     (lvl_sync)
   );

   irq_src_cfg #(.NUM_SRC(NUM_SRC)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .wr_region (region),
      .wr_word   (word_idx),
      .wr_data   (reg_wdata),
      .pol_q     (pol_q),
      .trig_q    (trig_q),
      .dual_q    (dual_q),
      .mask_q    (mask_q),
      .wedge_set (wedge_set),
      .wedge_clr (wedge_clr)
   );

   irq_src_detect #(.NUM_SRC(NUM_SRC)) i_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl_sync),
      .pol     (pol_q),
      .trig    (trig_q),
      .dual    (dual_q),
      .wset    (wedge_set),
      .wclr    (wedge_clr),
      .latch_q (latch_q),
      .pend    (pend)
   );

   assign irq_pend_masked = pend & mask_q;

   logic [PAD_W-1:0] pol_pad, trig_pad, dual_pad, mask_pad, pend_pad, src_pad;

   assign pol_pad  = PAD_W'(pol_q);
   assign trig_pad = PAD_W'(trig_q);
   assign dual_pad = PAD_W'(dual_q);
   assign mask_pad = PAD_W'(mask_q);
   assign pend_pad = PAD_W'(pend);

   always_comb begin
      src_pad = '0;
      unique case (region)
         RG_POL:           src_pad = pol_pad;
         RG_TRIG:          src_pad = trig_pad;
         RG_DUAL:          src_pad = dual_pad;
         RG_MSET, RG_MCLR: src_pad = mask_pad;
         RG_PEND:          src_pad = pend_pad;
         default:          src_pad = '0;
      endcase
   end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NW; w++) begin
         if (word_idx == WORD_W'(w)) begin
            reg_rdata = src_pad[w*WORD_BITS +: WORD_BITS];
         end
      end
   end
endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC = 40,
   parameter int unsigned WORD_W  = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_we,
   input logic [REGION_W+WORD_W-1:0] reg_addr,
   input logic [31:0]               reg_wdata,
   input logic [NUM_SRC-1:0]        mask,
   input logic [NUM_SRC-1:0]        latch,
   input logic [NUM_SRC-1:0]        wset,
   input logic [NUM_SRC-1:0]        wclr,
   input logic [NUM_SRC-1:0]        irq_out
);
   localparam int unsigned PAD_W = words_for(NUM_SRC) * WORD_BITS;
   localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_SRC{1'b1}});

   logic [2:0]        rg;
   logic              w0;
   logic [PAD_W-1:0]  mask_pad, latch_pad;
   logic [31:0]       valid0;
   logic [15:0]       num;
   logic              inj_set_v;
   logic [15:0]       inj_idx;

   assign rg        = reg_addr[REGION_W+WORD_W-1 -: REGION_W];
   assign w0        = (reg_addr[WORD_W-1:0] == '0);
   assign mask_pad  = PAD_W'(mask);
   assign latch_pad = PAD_W'(latch);
   assign valid0    = VALID[31:0];
   assign num       = reg_wdata[15:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_set_v <= 1'b0;
         inj_idx   <= '0;
      end else begin
         inj_set_v <= reg_we && (rg == 3'd6) && reg_wdata[31] && (32'(num) < NUM_SRC);
         inj_idx   <= num;
      end
   end

   assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && rg == 3'd3 && w0) |=>
         ((mask_pad[31:0] & $past(reg_wdata & valid0)) == $past(reg_wdata & valid0)));

   assert_enable_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && rg == 3'd4 && w0) |=> ((mask_pad[31:0] & $past(reg_wdata)) == 32'd0));

   assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_out & ~mask) == '0));

   assert_inject_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inj_set_v |-> latch_pad[inj_idx]);

   assert_oor_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && rg == 3'd6 && 32'(num) >= NUM_SRC) |-> (wset == '0 && wclr == '0));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
      assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (latch[i] && !wclr[i]) |=> latch[i]);
   end
endmodule

bind irq_src_bank irq_src_bank_chk #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .mask      (mask_q),
   .latch     (latch_q),
   .wset      (wedge_set),
   .wclr      (wedge_clr),
   .irq_out   (irq_pend_masked)
);

// File: tb/test_irq_src_bank.sv
`timescale 1ns/1ps
module test_irq_src_bank;
   localparam int NSRC   = 40;
   localparam int WORD_W = 1;
   localparam logic [2:0] R_POL = 3'd0, R_TRIG = 3'd1, R_DUAL = 3'd2, R_MSET = 3'd3,
                          R_MCLR = 3'd4, R_PEND = 3'd5, R_WEDGE = 3'd6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src_in = '0;
   logic              reg_we = 1'b0;
   logic [3:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [NSRC-1:0]   irq_pend_masked;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_src_bank #(.NUM_SRC(NSRC)) i_irq_src_bank (
      .clk             (clk),
      .rst_n           (rst_n),
      .src_in          (src_in),
      .reg_we          (reg_we),
      .reg_addr        (reg_addr),
      .reg_wdata       (reg_wdata),
      .reg_rdata       (reg_rdata),
      .irq_pend_masked (irq_pend_masked)
   );

   typedef struct {
      bit          is_irq;
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always @(negedge clk) begin
      item_t       it;
      logic [63:0] got;
      if (sb_q.size() > 0) begin
         it  = sb_q.pop_front();
         got = it.is_irq ? 64'(irq_pend_masked) : 64'(reg_rdata);
         checks++;
         if (got !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle(input int n);
      repeat (n) tick();
   endtask

   task automatic wr(input logic [2:0] rg, input int w, input logic [31:0] d);
      reg_we    = 1'b1;
      reg_addr  = {rg, WORD_W'(w)};
      reg_wdata = d;
      tick();
      reg_we    = 1'b0;
   endtask

   task automatic inject(input bit set, input int num);
      wr(R_WEDGE, 0, {set, 15'd0, 16'(num)});
   endtask

   task automatic rd(input logic [2:0] rg, input int w, input logic [31:0] exp, input string tag);
      item_t it;
      reg_addr = {rg, WORD_W'(w)};
      it.is_irq = 1'b0;
      it.exp    = 64'(exp);
      it.tag    = tag;
      sb_q.push_back(it);
      tick();
   endtask

   task automatic irq_chk(input logic [NSRC-1:0] exp, input string tag);
      item_t it;
      it.is_irq = 1'b1;
      it.exp    = 64'(exp);
      it.tag    = tag;
      sb_q.push_back(it);
      tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state, R10 upper bits
      rd(R_POL, 0, 32'hFFFF_FFFF, "R1 polarity word0");
      rd(R_POL, 1, 32'h0000_00FF, "R1 R10 polarity word1");
      rd(R_TRIG, 0, 32'h0, "R1 trigger");
      rd(R_DUAL, 0, 32'h0, "R1 any-edge");
      rd(R_MSET, 0, 32'h0, "R1 enable");
      rd(R_PEND, 0, 32'h0, "R1 pending");
      irq_chk('0, "R1 delivered");

      // R11 configuration: 0 high-level, 1 low-level, 2 rising, 3 falling, 4 any-edge with pol 0
      wr(R_POL, 0, 32'hFFFF_FFE5);
      wr(R_TRIG, 0, 32'h0000_001C);
      wr(R_DUAL, 0, 32'h0000_0010);
      rd(R_POL, 0, 32'hFFFF_FFE5, "R11 polarity readback");
      rd(R_TRIG, 0, 32'h0000_001C, "R11 trigger readback");
      rd(R_DUAL, 0, 32'h0000_0010, "R11 any-edge readback");

      // R2 enables
      wr(R_MSET, 0, 32'h0000_001F);
      rd(R_MSET, 0, 32'h0000_001F, "R2 set enables");
      wr(R_MCLR, 0, 32'h0000_0002);
      rd(R_MSET, 0, 32'h0000_001D, "R2 clear one enable");
      wr(R_MSET, 0, 32'h0);
      rd(R_MCLR, 0, 32'h0000_001D, "R2 zero write keeps enables");
      wr(R_MSET, 0, 32'h0000_0002);
      rd(R_MCLR, 0, 32'h0000_001F, "R2 re-enable");

      // R4 level mode
      rd(R_PEND, 0, 32'h0000_0002, "R4 low-level line idle-active");
      irq_chk(40'h02, "R3 delivered low-level");
      src_in = 40'h03;
      tick();
      rd(R_PEND, 0, 32'h0000_0002, "R4 one edge after change");
      rd(R_PEND, 0, 32'h0000_0001, "R4 two edges after change");
      irq_chk(40'h01, "R3 delivered high-level");
      src_in = 40'h02;
      settle(2);
      rd(R_PEND, 0, 32'h0, "R4 level released");

      // R5 rising edge
      src_in = 40'h06;
      settle(2);
      rd(R_PEND, 0, 32'h0, "R5 rising not yet captured");
      rd(R_PEND, 0, 32'h0000_0004, "R5 rising captured third edge");
      src_in = 40'h02;
      settle(4);
      rd(R_PEND, 0, 32'h0000_0004, "R5 rising sticky");
      // R5 falling edge
      src_in = 40'h0A;
      settle(4);
      rd(R_PEND, 0, 32'h0000_0004, "R5 falling line ignores rise");
      src_in = 40'h02;
      settle(3);
      rd(R_PEND, 0, 32'h0000_000C, "R5 falling captured");

      // R7 acknowledge and injection
      inject(1'b0, 2);
      rd(R_PEND, 0, 32'h0000_0008, "R7 clear line 2");
      inject(1'b0, 3);
      rd(R_PEND, 0, 32'h0, "R7 clear line 3");
      inject(1'b1, 5);
      rd(R_PEND, 0, 32'h0000_0020, "R7 set line 5");
      irq_chk('0, "R3 pending but disabled");
      wr(R_MSET, 0, 32'h0000_0020);
      irq_chk(40'h20, "R3 pending and enabled");
      inject(1'b0, 5);
      rd(R_PEND, 0, 32'h0, "R7 clear line 5");
      inject(1'b1, 39);
      rd(R_PEND, 1, 32'h0000_0080, "R7 set last line");
      rd(R_PEND, 0, 32'h0, "R7 last line only word1");
      inject(1'b0, 39);
      rd(R_PEND, 1, 32'h0, "R7 clear last line");

      // R6 any-edge
      src_in = 40'h12;
      settle(3);
      rd(R_PEND, 0, 32'h0000_0010, "R6 rise captured with pol 0");
      inject(1'b0, 4);
      rd(R_PEND, 0, 32'h0, "R6 cleared");
      src_in = 40'h02;
      settle(3);
      rd(R_PEND, 0, 32'h0000_0010, "R6 fall captured");
      inject(1'b0, 4);
      rd(R_PEND, 0, 32'h0, "R6 cleared again");

      // R8 out-of-range numbers
      inject(1'b1, 40);
      rd(R_PEND, 0, 32'h0, "R8 set 40 word0");
      rd(R_PEND, 1, 32'h0, "R8 set 40 word1");
      inject(1'b1, 63);
      rd(R_PEND, 1, 32'h0, "R8 set 63");
      inject(1'b1, 2);
      inject(1'b0, 42);
      rd(R_PEND, 0, 32'h0000_0004, "R8 clear 42 leaves line 2");
      inject(1'b0, 2);
      rd(R_PEND, 0, 32'h0, "R8 cleanup");

      // R9 edge and clear on the same clock edge
      inject(1'b1, 2);
      src_in = 40'h06;
      tick();
      tick();
      inject(1'b0, 2);
      rd(R_PEND, 0, 32'h0000_0004, "R9 edge beats clear");
      inject(1'b0, 2);
      rd(R_PEND, 0, 32'h0, "R9 clear without edge");

      // R10 bits beyond line count
      wr(R_POL, 1, 32'hFFFF_FFFF);
      rd(R_POL, 1, 32'h0000_00FF, "R10 polarity word1");
      wr(R_MSET, 1, 32'hFFFF_FFFF);
      rd(R_MSET, 1, 32'h0000_00FF, "R10 enable word1");
      wr(R_MCLR, 1, 32'h0000_0001);
      rd(R_MCLR, 1, 32'h0000_00FE, "R10 R2 clear in word1");
      rd(R_WEDGE, 0, 32'h0, "R11 injection region reads zero");

      tick();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL timeout (all requirements): actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule